// File: doc/BRIEF.md
# Dual-Modulus Pulse-Swallow Feedback Divider

This block divides a fast input clock by a programmable total ratio N = P·B + A and returns one single-cycle feedback pulse per N input cycles. This pulse is the feedback input for a phase comparator. The divider models the two-modulus prescaler as ordinary logic running on the input clock. The prescaler divides by P+1 while the modulus select is high and by P while it is low. A period counter steers that select: it counts completed prescaler periods against the swallow value A and the main value B.

A new pair of values is offered with a one-cycle load strobe. Each load is checked for legality. A legal pair is held in a staging register and is moved into the working counters only when an output cycle ends. Any output period is therefore computed entirely from one setting. An illegal pair raises the error flag and is discarded, and the divider keeps running on the last legal setting. This block has no streaming data path, so every pin is a plain control or status signal and there is no back-pressure.

Top module: `swallow_fbdiv`

## Requirements
- R1: While reset is asserted and directly after it, `fb_pulse` is 0 and `cfg_err` is 0. The setting is A = DEF_A and B = DEF_B (defaults 0 and 4, giving N = 256 with P = 64), so `mod_sel` is 0.
- R2: With a legal setting in force, consecutive `fb_pulse` assertions are exactly P·B + A input cycles apart.
- R3: In each output cycle, `mod_sel` is 1 for exactly A·(P+1) input cycles, starting from the first cycle after a pulse. It is 0 for the remaining (B−A)·P cycles, and it is 0 in the pulse cycle.
- R4: `fb_pulse` is high for exactly one input cycle per output cycle.
- R5: A legal load issued in the middle of an output cycle does not alter the length of that cycle. It takes effect from the next output cycle.
- R6: A load with B < 3 sets `cfg_err` on the next cycle, and the output period does not change.
- R7: A load with A ≥ P (with P = 64, A = 64 for example) sets `cfg_err` on the next cycle, and the output period does not change.
- R8: A load with A ≥ B sets `cfg_err` on the next cycle, and the output period does not change.
- R9: A legal load clears `cfg_err` on the next cycle. `cfg_err` changes only on a load.
- R10: With A = 0, `mod_sel` stays 0 throughout the output cycle, and the period is P·B. The smallest legal B (3) gives 3·P.
- R11: A legal load presented in the same cycle as `fb_pulse` already governs the output cycle that starts right after that pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast input clock that is being divided |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_stb | input | 1 | One-cycle strobe that offers a new A/B pair |
| ld_a | input | 7 | Swallow value A |
| ld_b | input | 11 | Main value B |
| fb_pulse | output | 1 | One-cycle pulse per N input cycles |
| mod_sel | output | 1 | Prescaler modulus select: 1 divides by P+1, 0 divides by P |
| cfg_err | output | 1 | Set by an illegal load, cleared by a legal one |

## Verification
A corrupted prescaler count, period count or working setting shows up as a wrong spacing of `fb_pulse` within one output cycle. A wrong swallow boundary shows up as the wrong number of `mod_sel` cycles in that same output cycle. A staging fault, either committing too early or committing an illegal pair, changes the length of the output cycle in which the load lands, or of the cycle after it. The bench therefore measures every output cycle in full, counting both its length and its `mod_sel` cycles, and compares the counts with the values that P, A and B predict.

// File: rtl/swallow_fbdiv_pkg.sv
package swallow_fbdiv_pkg;
  localparam int A_W = 7;
  localparam int B_W = 11;
  localparam int B_MIN = 3;

  typedef struct packed {
    logic [A_W-1:0] a;
    logic [B_W-1:0] b;
  } div_cfg_t;
endpackage

// File: rtl/swallow_fbdiv_cfg.sv
module swallow_fbdiv_cfg
  import swallow_fbdiv_pkg::*;
#(
  parameter int P     = 64,
  parameter int DEF_A = 0,
  parameter int DEF_B = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           ld_stb,
  input  logic [A_W-1:0] ld_a,
  input  logic [B_W-1:0] ld_b,
  input  logic           cyc_end,
  output div_cfg_t       work_cfg,
  output logic           cfg_err
);
  localparam div_cfg_t RST_CFG = '{a: A_W'(DEF_A), b: B_W'(DEF_B)};

  div_cfg_t stage_cfg;
  div_cfg_t next_stage;
  logic     legal;

  // legality of the offered pair
  always_comb begin
    legal = (ld_b >= B_W'(B_MIN)) &&
            (int'(ld_a) < P) &&
            (B_W'(ld_a) < ld_b);
    next_stage = (ld_stb && legal) ? '{a: ld_a, b: ld_b} : stage_cfg;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage_cfg <= RST_CFG;
      work_cfg  <= RST_CFG;
      cfg_err   <= 1'b0;
    end else begin
      stage_cfg <= next_stage;
      if (cyc_end) work_cfg <= next_stage;
      if (ld_stb) cfg_err <= !legal;
    end
  end
endmodule

// File: rtl/swallow_fbdiv_presc.sv
module swallow_fbdiv_presc #(
  parameter int P = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mod_sel,
  output logic pre_end
);
  localparam int PCW = $clog2(P + 1);
  localparam logic [PCW-1:0] TERM_HI = PCW'(P);
  localparam logic [PCW-1:0] TERM_LO = PCW'(P - 1);

  logic [PCW-1:0] pc;

  assign pre_end = (pc == (mod_sel ? TERM_HI : TERM_LO));

  always_ff @(posedge clk) begin
    if (!rst_n) pc <= '0;
    else if (pre_end) pc <= '0;
    else pc <= pc + 1'b1;
  end
endmodule

// File: rtl/swallow_fbdiv_seq.sv
module swallow_fbdiv_seq
  import swallow_fbdiv_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     pre_end,
  input  div_cfg_t work_cfg,
  output logic     mod_sel,
  output logic     last_per
);
  logic [B_W-1:0] k;

  assign mod_sel  = (k < B_W'(work_cfg.a));
  assign last_per = (k == work_cfg.b - 1'b1);

  always_ff @(posedge clk) begin
    if (!rst_n) k <= '0;
    else if (pre_end) k <= last_per ? '0 : k + 1'b1;
  end
endmodule

// File: rtl/swallow_fbdiv.sv
module swallow_fbdiv
  import swallow_fbdiv_pkg::*;
#(
  parameter int P     = 64,
  parameter int DEF_A = 0,
  parameter int DEF_B = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           ld_stb,
  input  logic [A_W-1:0] ld_a,
  input  logic [B_W-1:0] ld_b,
  output logic           fb_pulse,
  output logic           mod_sel,
  output logic           cfg_err
);
  div_cfg_t work_cfg;
  logic     pre_end;
  logic     last_per;
  logic     cyc_end;

  assign cyc_end  = pre_end && last_per;
  assign fb_pulse = cyc_end;

  swallow_fbdiv_cfg #(.P(P), .DEF_A(DEF_A), .DEF_B(DEF_B)) u_cfg (
    .clk(clk), .rst_n(rst_n), .ld_stb(ld_stb), .ld_a(ld_a), .ld_b(ld_b),
    .cyc_end(cyc_end), .work_cfg(work_cfg), .cfg_err(cfg_err)
  );

  swallow_fbdiv_presc #(.P(P)) u_presc (
    .clk(clk), .rst_n(rst_n), .mod_sel(mod_sel), .pre_end(pre_end)
  );

  swallow_fbdiv_seq u_seq (
    .clk(clk), .rst_n(rst_n), .pre_end(pre_end), .work_cfg(work_cfg),
    .mod_sel(mod_sel), .last_per(last_per)
  );
endmodule

// File: rtl/swallow_fbdiv_chk.sv
module swallow_fbdiv_chk
  import swallow_fbdiv_pkg::*;
#(
  parameter int P = 64
) (
  input logic           clk,
  input logic           rst_n,
  input logic           ld_stb,
  input logic [A_W-1:0] ld_a,
  input logic [B_W-1:0] ld_b,
  input logic           fb_pulse,
  input logic           mod_sel,
  input logic           cfg_err
);
  logic ok_pair;
  assign ok_pair = (ld_b >= B_W'(B_MIN)) && (int'(ld_a) < P) && (B_W'(ld_a) < ld_b);

  AST_PULSE_NARROW: assert property (@(posedge clk) disable iff (!rst_n)
    fb_pulse |=> !fb_pulse); // R4
  AST_MOD_LOW_AT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    fb_pulse |-> !mod_sel); // R3
  AST_MOD_RISE_AT_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mod_sel) |-> $past(fb_pulse)); // R3
  AST_ERR_SMALL_B: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_stb && ld_b < B_W'(B_MIN)) |=> cfg_err); // R6
  AST_ERR_BIG_A: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_stb && int'(ld_a) >= P) |=> cfg_err); // R7
  AST_ERR_A_NOT_BELOW_B: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_stb && B_W'(ld_a) >= ld_b) |=> cfg_err); // R8
  AST_ERR_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_stb && ok_pair) |=> !cfg_err); // R9
  AST_ERR_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_stb |=> $stable(cfg_err)); // R9
endmodule

bind swallow_fbdiv swallow_fbdiv_chk #(.P(P)) u_chk (
  .clk(clk), .rst_n(rst_n), .ld_stb(ld_stb), .ld_a(ld_a), .ld_b(ld_b),
  .fb_pulse(fb_pulse), .mod_sel(mod_sel), .cfg_err(cfg_err)
);

// File: tb/swallow_fbdiv_tb.sv
module swallow_fbdiv_tb;
  localparam int P = 64;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ld_stb = 1'b0;
  logic [6:0]  ld_a = '0;
  logic [10:0] ld_b = '0;
  logic        fb_pulse, mod_sel, cfg_err;

  int checks = 0;
  int failures = 0;
  int cyc = 0;

  always #5 clk = ~clk;

  swallow_fbdiv #(.P(P), .DEF_A(0), .DEF_B(4)) u_dut (
    .clk(clk), .rst_n(rst_n), .ld_stb(ld_stb), .ld_a(ld_a), .ld_b(ld_b),
    .fb_pulse(fb_pulse), .mod_sel(mod_sel), .cfg_err(cfg_err)
  );

  always @(negedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      failures++;
      $display("FAIL watchdog: actual=%0d cycles expected<=150000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_pulse();
    do @(negedge clk); while (!fb_pulse);
  endtask

  // measure one full output cycle starting right after a pulse
  task automatic measure(output int len, output int mh, output int wide);
    len = 0; mh = 0; wide = 0;
    do begin
      @(negedge clk);
      len++;
      if (mod_sel) mh++;
      if (len == 1 && fb_pulse) wide = 1;
    end while (!fb_pulse);
  endtask

  task automatic do_load(input int a, input int b);
    ld_a = 7'(a); ld_b = 11'(b); ld_stb = 1'b1;
    @(negedge clk);
    ld_stb = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 pulse in reset", int'(fb_pulse), 0);
    chk("R1 err in reset", int'(cfg_err), 0);
    chk("R1 mod in reset", int'(mod_sel), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 pulse after reset", int'(fb_pulse), 0);
    chk("R1 err after reset", int'(cfg_err), 0);
  endtask

  task automatic t_period(input string req, input int a, input int b);
    int len, mh, wide;
    measure(len, mh, wide);
    chk({req, " R2 period"}, len, P * b + a);
    chk({req, " R3 mod cycles"}, mh, a * (P + 1));
    chk({req, " R4 width"}, wide, 0);
  endtask

  // load mid-cycle: current cycle keeps old length
  task automatic t_mid_load(input int oa, input int ob, input int a, input int b);
    int len;
    wait_pulse();
    len = 0;
    repeat (10) begin @(negedge clk); len++; end
    do_load(a, b);
    len++;
    while (!fb_pulse) begin @(negedge clk); len++; end
    chk("R5 current cycle unchanged", len, P * ob + oa);
    chk("R9 err after legal load", int'(cfg_err), 0);
    t_period("R5 next cycle", a, b);
  endtask

  task automatic t_bad(input string req, input int a, input int b, input int oa, input int ob);
    wait_pulse();
    repeat (3) @(negedge clk);
    do_load(a, b);
    chk({req, " err set"}, int'(cfg_err), 1);
    wait_pulse();
    t_period({req, " setting kept"}, oa, ob);
    chk({req, " err held"}, int'(cfg_err), 1);
  endtask

  task automatic t_edge_load(input int a, input int b);
    int len;
    wait_pulse();
    do_load(a, b);
    len = 1;
    while (!fb_pulse) begin @(negedge clk); len++; end
    chk("R11 load at pulse applies next", len, P * b + a);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    wait_pulse();
    t_period("R10 default", 0, 4);
    t_mid_load(0, 4, 5, 10);
    t_mid_load(5, 10, 0, 3);
    t_period("R10 min B", 0, 3);
    t_mid_load(0, 3, 63, 100);
    t_bad("R6 B<3", 1, 2, 63, 100);
    t_bad("R7 A>=P", 64, 100, 63, 100);
    t_bad("R8 A>=B", 7, 7, 63, 100);
    t_mid_load(63, 100, 1, 4);
    chk("R9 err cleared", int'(cfg_err), 0);
    t_edge_load(9, 12);
    t_period("R11 following", 9, 12);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule